// File: doc/BRIEF.md
# Backplane Frame Receiver with Cyclic and Acyclic Buffers

This block is the receive side of a slave on a four-wire serial backplane link. It samples the link clock, the active-low select and the serial data line through synchronizers into the system clock domain, collects bytes most-significant bit first, and parses each select window as one frame. A frame is a class byte, a length byte, the payload and an additive checksum. Frames that pass every check are sorted by class. Cyclic I/O refresh frames replace the cyclic buffer as one unit. Acyclic diagnostic frames land in a separate, protected buffer and raise an interrupt to the local microcontroller.

The microcontroller reads both buffers at any time through a combinational register port: a buffer select, a byte index and the stored lengths. It releases the acyclic buffer with a one-cycle acknowledge. The link has no back-pressure. A frame that arrives when no space exists is dropped and flagged, and the link side never stalls.

Top module: `bpl_frame_rx`

## Requirements
- R1: A frame is the span during which `link_ssel_n` is low. Bits are taken on each rising edge of `link_sclk` while select is low, most significant bit first, eight bits per byte. The link clock half-period must be at least two system clock cycles.
- R2: Frame layout: class byte (0x01 cyclic, 0x02 acyclic), length byte N with 1 <= N <= MAX_LEN, N payload bytes, then one checksum byte equal to the payload sum modulo 256. The frame is judged when select rises.
- R3: A frame whose checksum byte differs from the payload sum changes neither buffer and adds one to `err_cnt`.
- R4: An unknown class byte, a length of 0 or above MAX_LEN, a select release before the checksum byte or inside a partial byte, or any byte after the checksum each discard the frame and add one to `err_cnt`. A select pulse with no clocked bits changes nothing.
- R5: A valid cyclic frame replaces `cyc_len` and all cyclic bytes in one system cycle, with no handshake. Bytes at indices at or beyond N read as zero.
- R6: A valid acyclic frame that arrives with the acyclic buffer empty is stored with its length, and `acy_irq` goes high.
- R7: An acyclic frame that arrives while `acy_irq` is high is dropped. The stored acyclic bytes and length stay unchanged, and `acy_ovr` goes high and stays high.
- R8: A one-cycle `acy_ack` clears `acy_irq` and `acy_ovr`, and the next valid acyclic frame is then accepted.
- R9: `rd_data` shows byte `rd_addr` of the cyclic buffer when `rd_sel` is 0 and of the acyclic buffer when `rd_sel` is 1. It responds combinationally and does not disturb reception.
- R10: After reset, both lengths, all bytes, `acy_irq`, `acy_ovr` and `err_cnt` are zero.
- R11: `err_cnt` is ERR_W bits wide and saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_sclk | input | 1 | Serial link clock, asynchronous |
| link_ssel_n | input | 1 | Active-low frame select, asynchronous |
| link_mosi | input | 1 | Serial data into the block |
| rd_sel | input | 1 | Buffer select for reads: 0 cyclic, 1 acyclic |
| rd_addr | input | $clog2(MAX_LEN) | Byte index for reads |
| rd_data | output | 8 | Selected buffer byte |
| cyc_len | output | $clog2(MAX_LEN+1) | Length of the current cyclic content |
| acy_len | output | $clog2(MAX_LEN+1) | Length of the held acyclic frame |
| acy_irq | output | 1 | Acyclic buffer occupied, interrupt request |
| acy_ovr | output | 1 | Sticky acyclic overrun flag |
| acy_ack | input | 1 | One-cycle release of the acyclic buffer |
| err_cnt | output | ERR_W | Saturating count of discarded frames |

## Verification
The assertions assume that the link obeys the clock ratio in R1. With that ratio, each synchronized link clock edge is a single-cycle pulse, and select never changes within two cycles of a clock edge. The assertions also assume that `acy_ack` is a single-cycle pulse. The bench drives all link lines from the falling system clock edge. It holds each link clock phase for four system cycles and keeps select steady for four cycles around the first and last bits. It pulses the acknowledge for exactly one cycle. Every sample then lands clear of the synchronizer settling window.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_CLASS,
    PS_LEN,
    PS_DATA,
    PS_SUM,
    PS_DONE,
    PS_BAD
  } parse_st_t;

  localparam logic [7:0] CLASS_CYC = 8'h01;
  localparam logic [7:0] CLASS_ACY = 8'h02;
endpackage

// File: rtl/bpl_link_sync.sv
module bpl_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic ssel_n_in,
  input  logic mosi_in,
  output logic sclk_rise,
  output logic ssel_fall,
  output logic ssel_rise,
  output logic sel_act,
  output logic mosi_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE_LVL = 3'b010; // sclk 0, ssel_n 1, mosi 0

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] chain [STAGES];
  logic [NSIG-1:0] last;

  assign raw = {mosi_in, ssel_n_in, sclk_in};

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= IDLE_LVL;
        else if (s == 0) chain[s] <= raw;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= IDLE_LVL;
    else last <= chain[STAGES-1];
  end

  assign sclk_rise = chain[STAGES-1][0] & ~last[0];
  assign ssel_fall = ~chain[STAGES-1][1] & last[1];
  assign ssel_rise = chain[STAGES-1][1] & ~last[1];
  assign sel_act   = ~chain[STAGES-1][1];
  assign mosi_s    = chain[STAGES-1][2];

  // R1: clock ratio gives isolated single-cycle edge pulses
  sclk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/bpl_frame_parser.sv
module bpl_frame_parser
  import bpl_pkg::*;
#(
  parameter int MAX_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_rise,
  input  logic ssel_fall,
  input  logic ssel_rise,
  input  logic sel_act,
  input  logic mosi_s,
  output logic [MAX_LEN-1:0][7:0] stage,
  output logic [$clog2(MAX_LEN+1)-1:0] frm_len,
  output logic cyc_load,
  output logic acy_load,
  output logic err_inc
);
  localparam int LEN_W = $clog2(MAX_LEN+1);
  localparam int IDX_W = $clog2(MAX_LEN);

  parse_st_t  st;
  logic [2:0] bitc;
  logic [6:0] shreg;
  logic [7:0] sum;
  logic [IDX_W-1:0] idx;
  logic       is_acy;
  logic       sum_ok;
  logic       got_bits;
  logic [7:0] nbyte;
  logic       byte_done;

  assign nbyte     = {shreg, mosi_s};
  assign byte_done = sclk_rise && sel_act && (st != PS_IDLE) && (bitc == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PS_IDLE;
      bitc     <= '0;
      shreg    <= '0;
      sum      <= '0;
      idx      <= '0;
      is_acy   <= 1'b0;
      sum_ok   <= 1'b0;
      got_bits <= 1'b0;
      frm_len  <= '0;
      stage    <= '0;
    end else if (ssel_fall) begin
      st       <= PS_CLASS;
      bitc     <= '0;
      sum      <= '0;
      idx      <= '0;
      sum_ok   <= 1'b0;
      got_bits <= 1'b0;
      stage    <= '0;
    end else if (ssel_rise) begin
      st <= PS_IDLE;
    end else if (sclk_rise && sel_act && st != PS_IDLE) begin
      got_bits <= 1'b1;
      shreg    <= nbyte[6:0];
      bitc     <= bitc + 3'd1;
      if (byte_done) begin
        unique case (st)
          PS_CLASS: begin
            if (nbyte == CLASS_CYC || nbyte == CLASS_ACY) begin
              is_acy <= (nbyte == CLASS_ACY);
              st     <= PS_LEN;
            end else st <= PS_BAD;
          end
          PS_LEN: begin
            if (nbyte >= 8'd1 && nbyte <= 8'(MAX_LEN)) begin
              frm_len <= nbyte[LEN_W-1:0];
              st      <= PS_DATA;
            end else st <= PS_BAD;
          end
          PS_DATA: begin
            stage[idx] <= nbyte;
            sum        <= sum + nbyte;
            idx        <= idx + 1'b1;
            if (LEN_W'(idx) + LEN_W'(1) == frm_len) st <= PS_SUM;
          end
          PS_SUM: begin
            sum_ok <= (nbyte == sum);
            st     <= PS_DONE;
          end
          PS_DONE: st <= PS_BAD;
          default: st <= PS_BAD;
        endcase
      end
    end
  end

  logic good;
  assign good = ssel_rise && (st == PS_DONE) && sum_ok && (bitc == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_load <= 1'b0;
      acy_load <= 1'b0;
      err_inc  <= 1'b0;
    end else begin
      cyc_load <= good && !is_acy;
      acy_load <= good && is_acy;
      err_inc  <= ssel_rise && (st != PS_IDLE) && !good && got_bits;
    end
  end

  // R3: a frame ends as exactly one of accepted-cyclic, accepted-acyclic or discarded
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cyc_load, acy_load, err_inc}));

  // R2: commit only follows a select release
  load_after_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_load || acy_load) |-> $past(ssel_rise));
endmodule

// File: rtl/bpl_dual_buf.sv
module bpl_dual_buf #(
  parameter int MAX_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [MAX_LEN-1:0][7:0] stage,
  input  logic [$clog2(MAX_LEN+1)-1:0] frm_len,
  input  logic cyc_load,
  input  logic acy_load,
  input  logic acy_ack,
  input  logic rd_sel,
  input  logic [$clog2(MAX_LEN)-1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [$clog2(MAX_LEN+1)-1:0] cyc_len,
  output logic [$clog2(MAX_LEN+1)-1:0] acy_len,
  output logic acy_full,
  output logic acy_ovr
);
  logic [MAX_LEN-1:0][7:0] cyc_mem;
  logic [MAX_LEN-1:0][7:0] acy_mem;
  logic free_now;

  assign free_now = !acy_full || acy_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_mem <= '0;
      cyc_len <= '0;
    end else if (cyc_load) begin
      cyc_mem <= stage;
      cyc_len <= frm_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acy_mem  <= '0;
      acy_len  <= '0;
      acy_full <= 1'b0;
      acy_ovr  <= 1'b0;
    end else begin
      if (acy_ack) begin
        acy_full <= 1'b0;
        acy_ovr  <= 1'b0;
      end
      if (acy_load && free_now) begin
        acy_mem  <= stage;
        acy_len  <= frm_len;
        acy_full <= 1'b1;
      end else if (acy_load) begin
        acy_ovr <= 1'b1;
      end
    end
  end

  assign rd_data = rd_sel ? acy_mem[rd_addr] : cyc_mem[rd_addr];

  // R5: cyclic content moves only on a commit
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_load |=> $stable(cyc_mem) && $stable(cyc_len));

  // R7
  acy_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acy_full && !acy_ack) |=> $stable(acy_mem) && $stable(acy_len) && acy_full);

  // R7
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acy_ovr) |-> $past(acy_load && acy_full));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acy_ack && !acy_load) |=> !acy_full && !acy_ovr);
endmodule

// File: rtl/bpl_frame_rx.sv
module bpl_frame_rx #(
  parameter int MAX_LEN = 16,
  parameter int ERR_W   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_sclk,
  input  logic link_ssel_n,
  input  logic link_mosi,
  input  logic rd_sel,
  input  logic [$clog2(MAX_LEN)-1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [$clog2(MAX_LEN+1)-1:0] cyc_len,
  output logic [$clog2(MAX_LEN+1)-1:0] acy_len,
  output logic acy_irq,
  output logic acy_ovr,
  input  logic acy_ack,
  output logic [ERR_W-1:0] err_cnt
);
  localparam int LEN_W = $clog2(MAX_LEN+1);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic sclk_rise, ssel_fall, ssel_rise, sel_act, mosi_s;
  logic [MAX_LEN-1:0][7:0] stage;
  logic [LEN_W-1:0] frm_len;
  logic cyc_load, acy_load, err_inc;

  bpl_link_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_in(link_sclk), .ssel_n_in(link_ssel_n), .mosi_in(link_mosi),
    .sclk_rise(sclk_rise), .ssel_fall(ssel_fall), .ssel_rise(ssel_rise),
    .sel_act(sel_act), .mosi_s(mosi_s)
  );

  bpl_frame_parser #(.MAX_LEN(MAX_LEN)) u_parse (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .ssel_fall(ssel_fall), .ssel_rise(ssel_rise),
    .sel_act(sel_act), .mosi_s(mosi_s),
    .stage(stage), .frm_len(frm_len),
    .cyc_load(cyc_load), .acy_load(acy_load), .err_inc(err_inc)
  );

  bpl_dual_buf #(.MAX_LEN(MAX_LEN)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .stage(stage), .frm_len(frm_len),
    .cyc_load(cyc_load), .acy_load(acy_load), .acy_ack(acy_ack),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .cyc_len(cyc_len), .acy_len(acy_len),
    .acy_full(acy_irq), .acy_ovr(acy_ovr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_cnt <= '0;
    else if (err_inc && err_cnt != ERR_MAX) err_cnt <= err_cnt + 1'b1;
  end

  // R11
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == ERR_MAX) |=> (err_cnt == ERR_MAX));

  // R4
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + 1'b1));
endmodule

// File: tb/sim_bpl_frame_rx.sv
module sim_bpl_frame_rx;
  localparam int ML = 16;
  localparam int EW = 8;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, ssel_n = 1, mosi = 0;
  logic rd_sel = 0;
  logic [3:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic [4:0] cyc_len, acy_len;
  logic acy_irq, acy_ovr, acy_ack = 0;
  logic [EW-1:0] err_cnt;

  int n_chk = 0, n_bad = 0;
  logic [7:0] e_cyc [ML];
  logic [7:0] e_acy [ML];
  int e_cyc_len = 0, e_acy_len = 0, e_err = 0;
  bit e_irq = 0, e_ovr = 0;

  always #10 clk = ~clk;

  bpl_frame_rx #(.MAX_LEN(ML), .ERR_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .link_sclk(sclk), .link_ssel_n(ssel_n),
    .link_mosi(mosi), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .cyc_len(cyc_len), .acy_len(acy_len), .acy_irq(acy_irq), .acy_ovr(acy_ovr),
    .acy_ack(acy_ack), .err_cnt(err_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'((seed * 37 + i * 13 + 5) & 255);
  endfunction

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      wcyc(4);
      sclk = 1;
      wcyc(4);
      sclk = 0;
    end
  endtask

  task automatic open_f();
    ssel_n = 0;
    wcyc(4);
  endtask

  task automatic close_f();
    wcyc(4);
    ssel_n = 1;
    wcyc(10);
  endtask

  // sends class, length, payload, checksum (+delta)
  task automatic send_frame(input int cls, input int len, input int seed, input int sum_delta);
    int s;
    s = 0;
    open_f();
    send_bits(8'(cls), 8);
    send_bits(8'(len), 8);
    for (int i = 0; i < len; i++) begin
      send_bits(pay(seed, i), 8);
      s += pay(seed, i);
    end
    send_bits(8'((s + sum_delta) & 255), 8);
    close_f();
  endtask

  task automatic model_good(input int cls, input int len, input int seed);
    if (cls == 1) begin
      for (int i = 0; i < ML; i++) e_cyc[i] = (i < len) ? pay(seed, i) : 8'h00;
      e_cyc_len = len;
    end else if (!e_irq) begin
      for (int i = 0; i < ML; i++) e_acy[i] = (i < len) ? pay(seed, i) : 8'h00;
      e_acy_len = len;
      e_irq = 1;
    end else e_ovr = 1;
  endtask

  task automatic err_model();
    if (e_err < 255) e_err++;
  endtask

  task automatic check_all(input string req);
    chk({req, " cyc_len"}, int'(cyc_len), e_cyc_len);
    chk({req, " acy_len"}, int'(acy_len), e_acy_len);
    chk({req, " irq"}, int'(acy_irq), int'(e_irq));
    chk({req, " ovr"}, int'(acy_ovr), int'(e_ovr));
    chk({req, " err_cnt"}, int'(err_cnt), e_err);
    for (int i = 0; i < ML; i++) begin
      rd_sel = 0; rd_addr = 4'(i); #1;
      chk({req, " R9 cyc byte"}, int'(rd_data), int'(e_cyc[i]));
      rd_sel = 1; #1;
      chk({req, " R9 acy byte"}, int'(rd_data), int'(e_acy[i]));
    end
  endtask

  task automatic ack();
    @(negedge clk); acy_ack = 1;
    @(negedge clk); acy_ack = 0;
    e_irq = 0; e_ovr = 0;
    wcyc(2);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < ML; i++) begin e_cyc[i] = 0; e_acy[i] = 0; end
    wcyc(3); rst_n = 1; wcyc(3);
    check_all("R10 reset");

    // R1/R2/R5: sweep every legal cyclic length, each replaces the last
    for (int n = 1; n <= ML; n++) begin
      send_frame(1, n, n, 0); model_good(1, n, n);
      check_all("R5 cyclic sweep");
    end
    // R5: shorter frame after longer zeroes the tail
    send_frame(1, 2, 99, 0); model_good(1, 2, 99);
    check_all("R5 shrink");

    // R3: checksum mismatch for several deltas
    for (int d = 1; d <= 3; d++) begin
      send_frame(1, 4, 50 + d, d * 41); err_model();
      check_all("R3 bad sum");
    end

    // R4: unknown class, bad lengths
    send_frame(3, 2, 7, 0); err_model(); check_all("R4 class");
    send_frame(0, 2, 7, 0); err_model(); check_all("R4 class zero");
    send_frame(1, 0, 7, 0); err_model(); check_all("R4 len zero");
    send_frame(2, 17, 7, 0); err_model(); check_all("R4 len high");
    // R4: early release inside payload
    open_f(); send_bits(8'h01, 8); send_bits(8'h05, 8); send_bits(8'h11, 8); close_f();
    err_model(); check_all("R4 early");
    // R4: release inside partial byte after a full good frame body
    open_f(); send_bits(8'h01, 8); send_bits(8'h01, 8); send_bits(8'h22, 8);
    send_bits(8'h22, 8); send_bits(8'hA5, 3); close_f();
    err_model(); check_all("R4 partial");
    // R4: extra byte after checksum
    open_f(); send_bits(8'h01, 8); send_bits(8'h01, 8); send_bits(8'h22, 8);
    send_bits(8'h22, 8); send_bits(8'h00, 8); close_f();
    err_model(); check_all("R4 extra");
    // R4: empty select pulse changes nothing
    open_f(); close_f(); check_all("R4 empty");

    // R6: acyclic accepted
    send_frame(2, 3, 200, 0); model_good(2, 3, 200); check_all("R6 acy");
    // R7: second acyclic dropped
    send_frame(2, 9, 201, 0); model_good(2, 9, 201); check_all("R7 overrun");
    // R5 while acyclic held: cyclic still replaced
    send_frame(1, 6, 202, 0); model_good(1, 6, 202); check_all("R5 cyc during hold");
    // R8: ack then new acyclic accepted
    ack(); check_all("R8 ack");
    send_frame(2, 16, 203, 0); model_good(2, 16, 203); check_all("R8 reaccept");
    ack(); check_all("R8 ack2");

    // R11: saturation of the discard counter
    for (int k = 0; k < 260; k++) begin
      open_f(); send_bits(8'h7E, 8); close_f(); err_model();
    end
    check_all("R11 saturate");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule